// File: doc/BRIEF.md
# LCD panel power and mode sequencer

This block turns high-level panel requests into an ordered stream of command descriptors for a downstream frame serializer. Every command the panel needs lives in a fixed on-chip ROM, grouped into named lists. Each list ends in a terminator word. The sequencer picks which lists to run for a request and walks them one after another. It hands each descriptor to the serializer over a valid/ready handshake.

Two kinds of request arrive as single-cycle strobes. A power request asks for the panel to be on or off. A mode request carries a horizontal resolution, and the block maps that value to one of two display modes. A model select input chooses between two panel variants, which differ in some of their mode lists. A color-invert enable decides whether the inversion command is sent or dropped. Two status outputs give the committed power state and the committed mode. A busy output shows that a sequence is running or a request is waiting.

If the serializer reports an error, the running sequence is abandoned and no status changes. Requests that arrive during a sequence are held until it finishes. Only the newest request of each kind is kept.

Top module: `panel_power_seq`

## Requirements
- R1: A descriptor is 32 bits: [31:30] holds the parameter count (0, 1 or 2), [23:16] the opcode, [15:8] the first parameter and [7:0] the second parameter, with unused bits zero. Every list ends in the terminator 32'hFFFF_FFFF, and the terminator never appears on `desc_data` while `desc_valid` is high.
- R2: Switching off to on sends five lists in this order: display-on (0x29, 0xB8 FF F9, 0x11, 0xB0 16), reset, the mode's pass-through list, the shared 27-command configuration list (it starts with 0xB8 FF F9), and the mode's transfer list (it ends with 0x21 and then 0x29). `power_on` goes to 1 only after the last of these lists has been sent.
- R3: The reset list is opcode 0x01 followed by three 0x00 commands, all with no parameters.
- R4: Switching on to off sends exactly four descriptors: 0x28, 0xB8 80 02, 0x10, 0xB0 00. `power_on` then goes to 0.
- R5: A power request equal to the current `power_on` sends no descriptor.
- R6: A mode request with resolution 640 or 480 selects VGA (`mode_vga`=1). Any other value selects QVGA (`mode_vga`=0).
- R7: A mode request equal to the current mode sends nothing. Otherwise the pass-through, configuration and transfer lists for the new mode are sent, and `mode_vga` is then updated.
- R8: After reset, `power_on`=0, `mode_vga`=1, `desc_valid`=0 and `seq_busy`=0.
- R9: When `invert_en` is 0 at the start of a sequence, the zero-parameter 0x21 descriptor (32'h0021_0000) is dropped from every list in that sequence.
- R10: Model 0 and model 1 differ in their VGA pass-through and VGA transfer lists. The model 1 pass-through list has no 0x36 command, and its VGA transfer list carries 0xD2 00 1E. Model 0 sends 0x36 50 and 0xD2 14 00. The configuration list and the QVGA transfer list are the same for both models.
- R11: A `ser_err` pulse during a list ends the sequence. No further descriptors are sent, and neither `power_on` nor `mode_vga` changes.
- R12: Requests that arrive while a sequence runs are held. A pending power request is served before a pending mode request. Only the most recent request of each kind is kept.
- R13: While `desc_valid` is high and `desc_ready` is low, `desc_valid` stays high and `desc_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req_v | input | 1 | Power request strobe |
| pwr_req_on | input | 1 | Requested power level (1 = on) |
| mode_req_v | input | 1 | Mode request strobe |
| mode_hres | input | HRES_W | Requested horizontal resolution |
| model_sel | input | 1 | Panel variant (0 or 1) |
| invert_en | input | 1 | Send the inversion command when 1 |
| desc_valid | output | 1 | Descriptor valid |
| desc_data | output | 32 | Descriptor word |
| desc_ready | input | 1 | Serializer accepts descriptor |
| ser_err | input | 1 | Serializer error pulse |
| power_on | output | 1 | Committed power state |
| mode_vga | output | 1 | Committed mode (1 = VGA) |
| seq_busy | output | 1 | Sequence running or request pending |

## Verification
Most internal faults show up in the descriptor stream itself, not in the status bits. A wrong list base or step counter puts a known command at the wrong index. A broken terminator test or filter changes the descriptor count of a sequence, which is visible within one sequence of a few dozen descriptors. A wrong commit or abort path shows in `power_on` or `mode_vga` a few cycles after the last descriptor or the error pulse. A pending-request fault shows as an extra sequence, or a missing one, after the running sequence ends.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  localparam int DESC_W = 32;
  localparam int ROM_AW = 7;

  localparam logic [DESC_W-1:0] END_WORD = '1;
  localparam logic [DESC_W-1:0] INV_WORD = 32'h0021_0000;

  // list start addresses inside the command ROM
  localparam int BASE_ON      = 0;
  localparam int BASE_RST     = 5;
  localparam int BASE_PT_VA   = 10;
  localparam int BASE_PT_QA   = 16;
  localparam int BASE_PT_VB   = 22;
  localparam int BASE_PT_QB   = 27;
  localparam int BASE_CFG     = 32;
  localparam int BASE_XF_VA   = 60;
  localparam int BASE_XF_Q    = 70;
  localparam int BASE_XF_VB   = 80;
  localparam int BASE_OFF     = 90;

  typedef enum logic [1:0] {SEQ_ON, SEQ_OFF, SEQ_MODE} seq_kind_e;

  function automatic logic [DESC_W-1:0] cmd0(input logic [7:0] op);
    return {2'd0, 6'd0, op, 16'd0};
  endfunction

  function automatic logic [DESC_W-1:0] cmd1(input logic [7:0] op, input logic [7:0] a);
    return {2'd1, 6'd0, op, a, 8'd0};
  endfunction

  function automatic logic [DESC_W-1:0] cmd2(input logic [7:0] op, input logic [7:0] a,
                                              input logic [7:0] b);
    return {2'd2, 6'd0, op, a, b};
  endfunction
endpackage

// File: rtl/panel_cmd_rom.sv
module panel_cmd_rom
  import panel_seq_pkg::*;
#(
  parameter int AW = ROM_AW,
  parameter int DW = DESC_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  function automatic logic [DW-1:0] word_at(input int a);
    case (a)
      // display-on list
      0:  return cmd0(8'h29);
      1:  return cmd2(8'hB8, 8'hFF, 8'hF9);
      2:  return cmd0(8'h11);
      3:  return cmd1(8'hB0, 8'h16);
      // reset list
      5:  return cmd0(8'h01);
      6:  return cmd0(8'h00);
      7:  return cmd0(8'h00);
      8:  return cmd0(8'h00);
      // pass-through, model 0, VGA
      10: return cmd1(8'hB0, 8'h16);
      11: return cmd1(8'hBC, 8'h80);
      12: return cmd1(8'hE1, 8'h00);
      13: return cmd1(8'h36, 8'h50);
      14: return cmd1(8'h3B, 8'h00);
      // pass-through, model 0, QVGA
      16: return cmd1(8'hB0, 8'h16);
      17: return cmd1(8'hBC, 8'h81);
      18: return cmd1(8'hE1, 8'h00);
      19: return cmd1(8'h36, 8'h50);
      20: return cmd1(8'h3B, 8'h22);
      // pass-through, model 1, VGA
      22: return cmd1(8'hB0, 8'h16);
      23: return cmd1(8'hBC, 8'h80);
      24: return cmd1(8'hE1, 8'h00);
      25: return cmd1(8'h3B, 8'h00);
      // pass-through, model 1, QVGA
      27: return cmd1(8'hB0, 8'h16);
      28: return cmd1(8'hBC, 8'h81);
      29: return cmd1(8'hE1, 8'h00);
      30: return cmd1(8'h3B, 8'h22);
      // shared configuration list
      32: return cmd2(8'hB8, 8'hFF, 8'hF9);
      33: return cmd0(8'h11);
      34: return cmd1(8'hBA, 8'h01);
      35: return cmd1(8'hBB, 8'h00);
      36: return cmd1(8'h3A, 8'h60);
      37: return cmd1(8'hBF, 8'h10);
      38: return cmd1(8'hB1, 8'h56);
      39: return cmd1(8'hB2, 8'h33);
      40: return cmd1(8'hB3, 8'h11);
      41: return cmd1(8'hB4, 8'h02);
      42: return cmd1(8'hB5, 8'h35);
      43: return cmd1(8'hB6, 8'h40);
      44: return cmd1(8'hB7, 8'h03);
      45: return cmd1(8'hBD, 8'h00);
      46: return cmd1(8'hBE, 8'h00);
      47: return cmd1(8'hC0, 8'h11);
      48: return cmd1(8'hC1, 8'h11);
      49: return cmd1(8'hC2, 8'h11);
      50: return cmd2(8'hC3, 8'h20, 8'h40);
      51: return cmd2(8'hC4, 8'h60, 8'hC0);
      52: return cmd2(8'hC5, 8'h10, 8'h20);
      53: return cmd1(8'hC6, 8'hC0);
      54: return cmd2(8'hC7, 8'h33, 8'h43);
      55: return cmd1(8'hC8, 8'h44);
      56: return cmd1(8'hC9, 8'h33);
      57: return cmd1(8'hCA, 8'h00);
      58: return cmd2(8'hEC, 8'h01, 8'hF0);
      // transfer, model 0, VGA
      60: return cmd1(8'hCF, 8'h02);
      61: return cmd2(8'hD0, 8'h08, 8'h04);
      62: return cmd1(8'hD1, 8'h01);
      63: return cmd2(8'hD2, 8'h14, 8'h00);
      64: return cmd2(8'hD3, 8'h1A, 8'h0F);
      65: return cmd2(8'hD4, 8'h1F, 8'hAF);
      66: return cmd1(8'hD5, 8'h14);
      67: return cmd0(8'h21);
      68: return cmd0(8'h29);
      // transfer, QVGA (both models)
      70: return cmd1(8'hD6, 8'h02);
      71: return cmd2(8'hD7, 8'h08, 8'h04);
      72: return cmd1(8'hD8, 8'h01);
      73: return cmd2(8'hD9, 8'h00, 8'h08);
      74: return cmd2(8'hDE, 8'h05, 8'h0A);
      75: return cmd2(8'hDF, 8'h0A, 8'h19);
      76: return cmd1(8'hE0, 8'h0A);
      77: return cmd0(8'h21);
      78: return cmd0(8'h29);
      // transfer, model 1, VGA
      80: return cmd1(8'hCF, 8'h02);
      81: return cmd2(8'hD0, 8'h08, 8'h04);
      82: return cmd1(8'hD1, 8'h01);
      83: return cmd2(8'hD2, 8'h00, 8'h1E);
      84: return cmd2(8'hD3, 8'h14, 8'h28);
      85: return cmd2(8'hD4, 8'h28, 8'h64);
      86: return cmd1(8'hD5, 8'h28);
      87: return cmd0(8'h21);
      88: return cmd0(8'h29);
      // power-off list
      90: return cmd0(8'h28);
      91: return cmd2(8'hB8, 8'h80, 8'h02);
      92: return cmd0(8'h10);
      93: return cmd1(8'hB0, 8'h00);
      default: return END_WORD;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    q <= word_at(int'(addr));
  end
endmodule

// File: rtl/panel_req_hold.sv
module panel_req_hold #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic         take,
  output logic         pend_v,
  output logic [W-1:0] pend_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (in_v) begin
      pend_v <= 1'b1;
      pend_d <= in_d;
    end else if (take) begin
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/panel_seq_plan.sv
module panel_seq_plan
  import panel_seq_pkg::*;
#(
  parameter int AW = ROM_AW
) (
  input  seq_kind_e     kind,
  input  logic [2:0]    step,
  input  logic          model_b,
  input  logic          tgt_vga,
  output logic [AW-1:0] base,
  output logic          last
);
  logic [AW-1:0] pt_base, xf_base;
  logic [2:0]    mode_step;

  always_comb begin
    if (tgt_vga) pt_base = model_b ? AW'(BASE_PT_VB) : AW'(BASE_PT_VA);
    else         pt_base = model_b ? AW'(BASE_PT_QB) : AW'(BASE_PT_QA);
    if (tgt_vga) xf_base = model_b ? AW'(BASE_XF_VB) : AW'(BASE_XF_VA);
    else         xf_base = AW'(BASE_XF_Q);
  end

  // the power-on sequence reuses the mode lists after its two leading lists
  assign mode_step = (kind == SEQ_ON) ? step - 3'd2 : step;

  always_comb begin
    base = AW'(BASE_OFF);
    last = 1'b1;
    case (kind)
      SEQ_OFF: begin
        base = AW'(BASE_OFF);
        last = 1'b1;
      end
      default: begin
        if (kind == SEQ_ON && step == 3'd0)      base = AW'(BASE_ON);
        else if (kind == SEQ_ON && step == 3'd1) base = AW'(BASE_RST);
        else if (mode_step == 3'd0)              base = pt_base;
        else if (mode_step == 3'd1)              base = AW'(BASE_CFG);
        else                                     base = xf_base;
        last = (mode_step == 3'd2);
      end
    endcase
  end
endmodule

// File: rtl/panel_list_walker.sv
module panel_list_walker
  import panel_seq_pkg::*;
#(
  parameter int AW = ROM_AW,
  parameter int DW = DESC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          skip_inv,
  input  logic [DW-1:0] rom_q,
  output logic [AW-1:0] rom_addr,
  input  logic          out_ready,
  input  logic          ser_err,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          busy,
  output logic          done,
  output logic          aborted
);
  typedef enum logic [1:0] {W_IDLE, W_WAIT, W_EVAL, W_SEND} wstate_e;
  wstate_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      rom_addr  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      if (st != W_IDLE && ser_err) begin
        st        <= W_IDLE;
        out_valid <= 1'b0;
        aborted   <= 1'b1;
      end else begin
        case (st)
          W_IDLE: if (start) begin
            rom_addr <= base;
            st       <= W_WAIT;
          end
          W_WAIT: st <= W_EVAL;
          W_EVAL: begin
            if (rom_q == END_WORD[DW-1:0]) begin
              done <= 1'b1;
              st   <= W_IDLE;
            end else if (skip_inv && rom_q == INV_WORD[DW-1:0]) begin
              rom_addr <= rom_addr + 1'b1;
              st       <= W_WAIT;
            end else begin
              out_valid <= 1'b1;
              out_data  <= rom_q;
              st        <= W_SEND;
            end
          end
          W_SEND: if (out_ready) begin
            out_valid <= 1'b0;
            rom_addr  <= rom_addr + 1'b1;
            st        <= W_WAIT;
          end
          default: st <= W_IDLE;
        endcase
      end
    end
  end

  assign busy = (st != W_IDLE);
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int HRES_W = 12,
  parameter int VGA_W0 = 640,
  parameter int VGA_W1 = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_req_v,
  input  logic              pwr_req_on,
  input  logic              mode_req_v,
  input  logic [HRES_W-1:0] mode_hres,
  input  logic              model_sel,
  input  logic              invert_en,
  output logic              desc_valid,
  output logic [31:0]       desc_data,
  input  logic              desc_ready,
  input  logic              ser_err,
  output logic              power_on,
  output logic              mode_vga,
  output logic              seq_busy
);
  localparam int AW = ROM_AW;

  typedef enum logic [1:0] {T_IDLE, T_LAUNCH, T_RUN} tstate_e;
  tstate_e   st;
  seq_kind_e kind;
  logic [2:0] step;
  logic      tgt_vga, tgt_pwr, model_l, inv_l;

  logic pwr_pend_v, pwr_pend_d, pwr_take;
  logic mode_pend_v, mode_pend_d, mode_take;
  logic req_is_vga;

  logic [AW-1:0] plan_base, rom_addr;
  logic          plan_last;
  logic [31:0]   rom_q;
  logic          walk_start, walk_busy, walk_done, walk_abort;

  assign req_is_vga = (mode_hres == HRES_W'(VGA_W0)) || (mode_hres == HRES_W'(VGA_W1));

  panel_req_hold #(.W(1)) u_pwr_hold (
    .clk(clk), .rst(rst), .in_v(pwr_req_v), .in_d(pwr_req_on),
    .take(pwr_take), .pend_v(pwr_pend_v), .pend_d(pwr_pend_d)
  );

  panel_req_hold #(.W(1)) u_mode_hold (
    .clk(clk), .rst(rst), .in_v(mode_req_v), .in_d(req_is_vga),
    .take(mode_take), .pend_v(mode_pend_v), .pend_d(mode_pend_d)
  );

  assign pwr_take  = (st == T_IDLE) && pwr_pend_v;
  assign mode_take = (st == T_IDLE) && !pwr_pend_v && mode_pend_v;

  panel_seq_plan #(.AW(AW)) u_plan (
    .kind(kind), .step(step), .model_b(model_l), .tgt_vga(tgt_vga),
    .base(plan_base), .last(plan_last)
  );

  panel_cmd_rom #(.AW(AW), .DW(32)) u_rom (
    .clk(clk), .addr(rom_addr), .q(rom_q)
  );

  assign walk_start = (st == T_LAUNCH);

  panel_list_walker #(.AW(AW), .DW(32)) u_walk (
    .clk(clk), .rst(rst), .start(walk_start), .base(plan_base), .skip_inv(!inv_l),
    .rom_q(rom_q), .rom_addr(rom_addr), .out_ready(desc_ready), .ser_err(ser_err),
    .out_valid(desc_valid), .out_data(desc_data), .busy(walk_busy),
    .done(walk_done), .aborted(walk_abort)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      kind     <= SEQ_OFF;
      step     <= '0;
      tgt_vga  <= 1'b1;
      tgt_pwr  <= 1'b0;
      model_l  <= 1'b0;
      inv_l    <= 1'b1;
      power_on <= 1'b0;
      mode_vga <= 1'b1;
    end else begin
      case (st)
        T_IDLE: begin
          if (pwr_pend_v) begin
            if (pwr_pend_d != power_on) begin
              kind    <= pwr_pend_d ? SEQ_ON : SEQ_OFF;
              tgt_pwr <= pwr_pend_d;
              tgt_vga <= mode_vga;
              step    <= '0;
              model_l <= model_sel;
              inv_l   <= invert_en;
              st      <= T_LAUNCH;
            end
          end else if (mode_pend_v) begin
            if (mode_pend_d != mode_vga) begin
              kind    <= SEQ_MODE;
              tgt_vga <= mode_pend_d;
              step    <= '0;
              model_l <= model_sel;
              inv_l   <= invert_en;
              st      <= T_LAUNCH;
            end
          end
        end
        T_LAUNCH: st <= T_RUN;
        T_RUN: begin
          if (walk_abort) begin
            st <= T_IDLE;
          end else if (walk_done) begin
            if (plan_last) begin
              if (kind == SEQ_MODE) mode_vga <= tgt_vga;
              else                  power_on <= tgt_pwr;
              st <= T_IDLE;
            end else begin
              step <= step + 3'd1;
              st   <= T_LAUNCH;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign seq_busy = (st != T_IDLE) || pwr_pend_v || mode_pend_v;
endmodule

// File: rtl/panel_power_seq_chk.sv
module panel_power_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        desc_valid,
  input logic        desc_ready,
  input logic [31:0] desc_data,
  input logic        ser_err,
  input logic        power_on,
  input logic        mode_vga,
  input logic        inv_l,
  input logic        walk_busy
);
  // R1
  no_terminator_out_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> desc_data != 32'hFFFF_FFFF);

  // R9
  inv_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !inv_l) |-> desc_data != 32'h0021_0000);

  // R13
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready && !ser_err) |=> (desc_valid && $stable(desc_data)));

  // R11
  err_keeps_power_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_err && walk_busy) |=> ($stable(power_on) && $stable(mode_vga)));

  // R11
  err_stops_stream_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_err && walk_busy) |=> !desc_valid);
endmodule

bind panel_power_seq panel_power_seq_chk u_chk (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_data(desc_data), .ser_err(ser_err), .power_on(power_on),
  .mode_vga(mode_vga), .inv_l(inv_l), .walk_busy(walk_busy)
);

// File: tb/panel_power_seq_test.sv
`timescale 1ns/1ps
module panel_power_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_req_v = 1'b0, pwr_req_on = 1'b0;
  logic        mode_req_v = 1'b0;
  logic [11:0] mode_hres = '0;
  logic        model_sel = 1'b0, invert_en = 1'b1;
  logic        desc_valid, desc_ready;
  logic [31:0] desc_data;
  logic        ser_err = 1'b0;
  logic        power_on, mode_vga, seq_busy;
  logic        bp_en = 1'b0;
  logic        rdy_q = 1'b1;

  int checks = 0, errors = 0;
  int xcnt = 0;
  int base_ix;
  logic [31:0] cap [0:63];
  bit term_seen = 0;

  always #5 clk = ~clk;

  panel_power_seq uut (
    .clk(clk), .rst(rst), .pwr_req_v(pwr_req_v), .pwr_req_on(pwr_req_on),
    .mode_req_v(mode_req_v), .mode_hres(mode_hres), .model_sel(model_sel),
    .invert_en(invert_en), .desc_valid(desc_valid), .desc_data(desc_data),
    .desc_ready(desc_ready), .ser_err(ser_err), .power_on(power_on),
    .mode_vga(mode_vga), .seq_busy(seq_busy)
  );

  assign desc_ready = rdy_q;

  always @(negedge clk) rdy_q <= bp_en ? ~rdy_q : 1'b1;

  always @(posedge clk) begin
    if (!rst && desc_valid && desc_ready) begin
      cap[xcnt % 64] <= desc_data;
      if (desc_data == 32'hFFFF_FFFF) term_seen <= 1'b1;
      xcnt <= xcnt + 1;
    end
  end

  function automatic logic [31:0] e0(input logic [7:0] op);
    return {8'h00, op, 16'h0000};
  endfunction
  function automatic logic [31:0] e1(input logic [7:0] op, input logic [7:0] a);
    return {8'h40, op, a, 8'h00};
  endfunction
  function automatic logic [31:0] e2(input logic [7:0] op, input logic [7:0] a,
                                     input logic [7:0] b);
    return {8'h80, op, a, b};
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] got(input int i);
    return cap[(base_ix + i) % 64];
  endfunction

  task automatic chk_word(input int i, input logic [31:0] exp, input string what);
    chk(got(i) == exp, what, got(i), exp);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (seq_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic req_power(input logic on);
    @(negedge clk);
    pwr_req_on = on; pwr_req_v = 1'b1;
    @(negedge clk);
    pwr_req_v = 1'b0;
  endtask

  task automatic req_mode(input int hres);
    @(negedge clk);
    mode_hres = 12'(hres); mode_req_v = 1'b1;
    @(negedge clk);
    mode_req_v = 1'b0;
  endtask

  task automatic t_reset();
    chk(power_on == 1'b0, "R8 power after reset", power_on, 0);
    chk(mode_vga == 1'b1, "R8 mode after reset", mode_vga, 1);
    chk(desc_valid == 1'b0 && seq_busy == 1'b0, "R8 idle after reset",
        {desc_valid, seq_busy}, 0);
  endtask

  task automatic t_power_on_a_vga();
    base_ix = xcnt;
    req_power(1'b1);
    wait_idle();
    chk(xcnt - base_ix == 49, "R2 power-on count model0 VGA", xcnt - base_ix, 49);
    chk_word(0, e0(8'h29), "R2 first list display on");
    chk_word(1, e2(8'hB8, 8'hFF, 8'hF9), "R1 two-parameter layout");
    chk_word(4, e0(8'h01), "R3 reset opcode");
    chk_word(7, e0(8'h00), "R3 third nop");
    chk_word(8, e1(8'hB0, 8'h16), "R2 pass-through follows reset");
    chk_word(11, e1(8'h36, 8'h50), "R10 model0 VGA pass-through has 0x36");
    chk_word(13, e2(8'hB8, 8'hFF, 8'hF9), "R2 config follows pass-through");
    chk_word(43, e2(8'hD2, 8'h14, 8'h00), "R10 model0 VGA transfer");
    chk_word(47, e0(8'h21), "R9 inversion sent when enabled");
    chk_word(48, e0(8'h29), "R2 transfer ends display on");
    chk(power_on == 1'b1, "R2 power committed", power_on, 1);
  endtask

  task automatic t_same_power();
    base_ix = xcnt;
    req_power(1'b1);
    wait_idle();
    chk(xcnt == base_ix, "R5 repeated on sends nothing", xcnt - base_ix, 0);
  endtask

  task automatic t_same_mode();
    base_ix = xcnt;
    req_mode(640);
    wait_idle();
    chk(xcnt == base_ix, "R7 same mode sends nothing", xcnt - base_ix, 0);
  endtask

  task automatic t_mode_qvga();
    base_ix = xcnt;
    req_mode(320);
    wait_idle();
    chk(xcnt - base_ix == 41, "R7 mode change count", xcnt - base_ix, 41);
    chk_word(1, e1(8'hBC, 8'h81), "R6 QVGA pass-through");
    chk_word(5, e2(8'hB8, 8'hFF, 8'hF9), "R7 config in mode change");
    chk(mode_vga == 1'b0, "R6 320 selects QVGA", mode_vga, 0);
  endtask

  task automatic t_mode_vga_b();
    model_sel = 1'b1;
    base_ix = xcnt;
    req_mode(480);
    wait_idle();
    chk(xcnt - base_ix == 40, "R10 model1 VGA count", xcnt - base_ix, 40);
    chk_word(1, e1(8'hBC, 8'h80), "R10 model1 VGA pass-through");
    chk_word(3, e1(8'h3B, 8'h00), "R10 model1 has no 0x36");
    chk_word(34, e2(8'hD2, 8'h00, 8'h1E), "R10 model1 VGA transfer");
    chk(mode_vga == 1'b1, "R6 480 selects VGA", mode_vga, 1);
  endtask

  task automatic t_no_invert();
    bit found = 0;
    invert_en = 1'b0;
    base_ix = xcnt;
    req_mode(100);
    wait_idle();
    chk(xcnt - base_ix == 39, "R9 inversion dropped count", xcnt - base_ix, 39);
    for (int i = 0; i < 39; i++) if (got(i) == e0(8'h21)) found = 1;
    chk(!found, "R9 no inversion word", found, 0);
    chk_word(38, e0(8'h29), "R9 display on still sent");
    chk(mode_vga == 1'b0, "R6 100 selects QVGA", mode_vga, 0);
  endtask

  task automatic t_power_off();
    base_ix = xcnt;
    req_power(1'b0);
    wait_idle();
    chk(xcnt - base_ix == 4, "R4 off count", xcnt - base_ix, 4);
    chk_word(0, e0(8'h28), "R4 display off");
    chk_word(1, e2(8'hB8, 8'h80, 8'h02), "R4 output control");
    chk_word(2, e0(8'h10), "R4 sleep in");
    chk_word(3, e1(8'hB0, 8'h00), "R4 deep standby");
    chk(power_on == 1'b0, "R4 power cleared", power_on, 0);
  endtask

  task automatic t_backpressure_pending();
    bp_en = 1'b1;
    base_ix = xcnt;
    req_power(1'b1);
    repeat (20) @(negedge clk);
    req_mode(640);
    req_mode(100);
    wait_idle();
    bp_en = 1'b0;
    chk(xcnt - base_ix == 47, "R13 power-on under backpressure", xcnt - base_ix, 47);
    chk(power_on == 1'b1, "R2 power on after backpressure", power_on, 1);
    chk(mode_vga == 1'b0, "R12 newest held mode kept", mode_vga, 0);
  endtask

  task automatic t_pending_after_off();
    base_ix = xcnt;
    req_power(1'b0);
    req_mode(100);
    req_mode(640);
    wait_idle();
    chk(xcnt - base_ix == 43, "R12 off then held VGA change", xcnt - base_ix, 43);
    chk_word(0, e0(8'h28), "R12 power request served first");
    chk_word(5, e1(8'hBC, 8'h80), "R12 held mode runs after");
    chk(mode_vga == 1'b1 && power_on == 1'b0, "R12 final status",
        {power_on, mode_vga}, 1);
  endtask

  task automatic t_error_abort();
    int stop_at;
    model_sel = 1'b0; invert_en = 1'b1;
    base_ix = xcnt;
    req_power(1'b1);
    while (xcnt - base_ix < 10) @(negedge clk);
    ser_err = 1'b1;
    @(negedge clk);
    ser_err = 1'b0;
    stop_at = xcnt;
    wait_idle();
    chk(xcnt == stop_at, "R11 nothing sent after error", xcnt - stop_at, 0);
    chk(power_on == 1'b0, "R11 power unchanged on error", power_on, 0);
    chk(mode_vga == 1'b1 && desc_valid == 1'b0, "R11 mode kept, stream idle",
        {mode_vga, desc_valid}, 2);
  endtask

  task automatic t_recover();
    base_ix = xcnt;
    req_power(1'b1);
    wait_idle();
    chk(xcnt - base_ix == 49, "R2 full power-on after abort", xcnt - base_ix, 49);
    chk_word(4, e0(8'h01), "R3 reset after abort");
    chk(power_on == 1'b1, "R2 power on after recovery", power_on, 1);
    chk(!term_seen, "R1 terminator never sent", term_seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_power_on_a_vga();
    t_same_power();
    t_same_mode();
    t_mode_qvga();
    t_mode_vga_b();
    t_no_invert();
    t_power_off();
    t_backpressure_pending();
    t_pending_after_off();
    t_error_abort();
    t_recover();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule